// File: doc/BRIEF.md
# Bit-Alias Access Translator

This block sits on the path between a 32-bit memory-mapped bus master and a word-addressed slave (memory or register file). Two regions of the slave address space can be reached one bit at a time. Each region spans 1 MB, and each bit in it has its own 32-bit word in a 32 MB alias window. A master that reads an alias word gets that single bit back in bit 0. A master that writes an alias word changes only that bit, and the translator does the change as one locked read-modify-write on the slave.

Every other address goes straight through as a single slave transaction, with no change. This includes addresses inside the two bit regions themselves. The master channel and the slave channel each use a valid/ready request, and each accepted request gets exactly one response pulse. The translator handles one master request at a time, so software needs no lock and no read-modify-write loop of its own.

Top module: `bitband_xlate`

## Requirements
- R1: An access outside both alias windows is sent to the slave as exactly one transaction. Its address, direction and write data are unchanged. This holds for addresses inside a bit region too. A passthrough read returns the slave word unchanged.
- R2: In the low alias window (base 0x2200_0000, region base 0x2000_0000), the alias address A selects slave word 0x2000_0000 + {A[24:7],2'b00} and bit A[6:2] of that word. For example, 0x2200_6008 selects word 0x2000_0300, bit 2.
- R3: The high alias window (base 0x4200_0000) maps the same way onto region base 0x4000_0000. For example, 0x4200_023C selects word 0x4000_0010, bit 15.
- R4: An alias read performs one slave read of the selected word. It returns 0x0000_0001 if the selected bit is 1 and 0x0000_0000 if it is 0.
- R5: An alias write reads the selected word and then writes it back. Only the selected bit changes, and its new value is bit 0 of the write data. Bits [31:1] of the write data have no effect.
- R6: During an alias write, the lock output is high on both the slave read and the slave write. The master ready stays low from acceptance until the write response, so no other access can come between the read and the write.
- R7: The master response pulse comes in the same cycle as the slave response to the last slave transaction of that request.
- R8: After reset, the master ready is high, and the slave request valid and master response valid are low.
- R9: A slave request that is not yet accepted keeps its valid, direction, address and data unchanged until the slave accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mReqValid | input | 1 | Master request valid |
| mReqReady | output | 1 | Master request accepted this cycle when valid |
| mReqWrite | input | 1 | Master request is a write |
| mReqAddr | input | 32 | Master byte address |
| mReqWdata | input | 32 | Master write data |
| mRspValid | output | 1 | Master response pulse |
| mRspRdata | output | 32 | Master read data (meaningful for reads) |
| sReqValid | output | 1 | Slave request valid |
| sReqReady | input | 1 | Slave accepts the request |
| sReqWrite | output | 1 | Slave request is a write |
| sReqAddr | output | 32 | Slave word address |
| sReqWdata | output | 32 | Slave write data |
| sLock | output | 1 | High while an alias read-modify-write holds the slave |
| sRspValid | input | 1 | Slave response pulse |
| sRspRdata | input | 32 | Slave read data |

## Verification
Master ready returns one cycle after the final slave response. The master response pulse falls in the same cycle as the slave response that ends the request: the first one for passthrough accesses and alias reads, the second one for alias writes. The bench's slave model answers one cycle after it accepts a request, and it stalls ready in a repeating pattern. The monitor samples at the falling edge of the clock, pops the expected result whenever it sees a master response, and checks that the slave response is present in that same cycle. After each request, the driver checks the slave transactions that request produced against the mapping it computed itself.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_WREQ,
    ST_WRSP
  } xlate_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;        // capture a new master request
    logic capture;     // capture the slave read word of an alias write
    logic writePhase;  // second (write) half of the read-modify-write
  } ctrl_strobe_t;

endpackage

// File: rtl/bb_datapath.sv
module bb_datapath
  import bitband_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int REGION_BITS = 20,
  parameter logic [NUM_REGIONS-1:0][31:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000},
  parameter logic [31:0] ALIAS_OFFSET = 32'h0200_0000
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  input  logic [31:0]  mReqAddr,
  input  logic [31:0]  mReqWdata,
  input  logic         mReqWrite,
  input  logic [31:0]  sRspRdata,
  input  logic         sReqValid,
  input  logic         sReqReady,
  input  logic         mRspValid,
  output logic         isAliasQ,
  output logic         isWriteQ,
  output logic [31:0]  sReqAddr,
  output logic [31:0]  sReqWdata,
  output logic [31:0]  mRspRdata
);

  localparam int WIN_BITS = REGION_BITS + 5;  // 32 alias bytes per target byte

  logic [NUM_REGIONS-1:0]       hitVec;
  logic [NUM_REGIONS-1:0][31:0] wordVec;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    localparam logic [31:0] ALIAS_BASE = REGION_BASE[g] + ALIAS_OFFSET;
    logic [31:0] offs;
    always_comb begin
      offs = '0;
      offs[REGION_BITS-1:0] = {mReqAddr[WIN_BITS-1:7], 2'b00};
    end
    assign hitVec[g]  = (mReqAddr[31:WIN_BITS] == ALIAS_BASE[31:WIN_BITS]);
    assign wordVec[g] = REGION_BASE[g] | offs;
  end

  logic        anyHit;
  logic [31:0] hitWord;
  always_comb begin
    anyHit  = 1'b0;
    hitWord = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hitVec[i]) begin
        anyHit  = 1'b1;
        hitWord = hitWord | wordVec[i];
      end
    end
  end

  logic [31:0] sAddrQ;
  logic [31:0] wdataQ;
  logic [4:0]  bitIdxQ;
  logic        wbitQ;
  logic [31:0] modWordQ;
  logic [31:0] modWord;

  always_comb begin
    modWord = sRspRdata;
    modWord[bitIdxQ] = wbitQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sAddrQ   <= '0;
      wdataQ   <= '0;
      bitIdxQ  <= '0;
      wbitQ    <= 1'b0;
      isAliasQ <= 1'b0;
      isWriteQ <= 1'b0;
      modWordQ <= '0;
    end else begin
      if (strobe.load) begin
        sAddrQ   <= anyHit ? hitWord : mReqAddr;
        wdataQ   <= mReqWdata;
        bitIdxQ  <= mReqAddr[6:2];
        wbitQ    <= mReqWdata[0];
        isAliasQ <= anyHit;
        isWriteQ <= mReqWrite;
      end
      if (strobe.capture) modWordQ <= modWord;
    end
  end

  assign sReqAddr  = sAddrQ;
  assign sReqWdata = strobe.writePhase ? modWordQ : wdataQ;
  assign mRspRdata = isAliasQ ? {31'b0, sRspRdata[bitIdxQ]} : sRspRdata;

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sReqValid && !sReqReady) |=> ($stable(sReqAddr) && $stable(sReqWdata)));

  assert_alias_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mRspValid && isAliasQ && !isWriteQ) |-> (mRspRdata[31:1] == 31'b0));

  assert_written_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sReqValid && strobe.writePhase) |-> (sReqWdata[bitIdxQ] == wbitQ));

endmodule

// File: rtl/bb_control.sv
module bb_control
  import bitband_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         mReqValid,
  input  logic         sReqReady,
  input  logic         sRspValid,
  input  logic         isAliasQ,
  input  logic         isWriteQ,
  output logic         mReqReady,
  output logic         mRspValid,
  output logic         sReqValid,
  output logic         sReqWrite,
  output logic         sLock,
  output ctrl_strobe_t strobe
);

  xlate_state_t state, nextState;
  logic rmw;

  assign rmw = isAliasQ && isWriteQ;

  always_comb begin
    nextState  = state;
    mReqReady  = 1'b0;
    mRspValid  = 1'b0;
    sReqValid  = 1'b0;
    sReqWrite  = 1'b0;
    sLock      = 1'b0;
    strobe     = '0;
    unique case (state)
      ST_IDLE: begin
        mReqReady = 1'b1;
        if (mReqValid) begin
          strobe.load = 1'b1;
          nextState   = ST_REQ;
        end
      end
      ST_REQ: begin
        sReqValid = 1'b1;
        sReqWrite = isWriteQ && !isAliasQ;
        sLock     = rmw;
        if (sReqReady) nextState = ST_RSP;
      end
      ST_RSP: begin
        sLock = rmw;
        if (sRspValid) begin
          if (rmw) begin
            strobe.capture = 1'b1;
            nextState      = ST_WREQ;
          end else begin
            mRspValid = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_WREQ: begin
        sReqValid         = 1'b1;
        sReqWrite         = 1'b1;
        sLock             = 1'b1;
        strobe.writePhase = 1'b1;
        if (sReqReady) nextState = ST_WRSP;
      end
      ST_WRSP: begin
        sLock             = 1'b1;
        strobe.writePhase = 1'b1;
        if (sRspValid) begin
          mRspValid = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mReqValid && mReqReady) |=> !mReqReady);

  assert_lock_on_rmw_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sReqValid && isAliasQ && isWriteQ) |-> sLock);

  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sReqValid && !sReqReady) |=> (sReqValid && $stable(sReqWrite)));

  assert_rsp_with_slave_R7: assert property (@(posedge clk) disable iff (!rstN)
    mRspValid |-> sRspValid);

  assert_no_req_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    mReqReady |-> !sReqValid);

endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bitband_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int REGION_BITS = 20,
  parameter logic [NUM_REGIONS-1:0][31:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000},
  parameter logic [31:0] ALIAS_OFFSET = 32'h0200_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mReqValid,
  output logic        mReqReady,
  input  logic        mReqWrite,
  input  logic [31:0] mReqAddr,
  input  logic [31:0] mReqWdata,
  output logic        mRspValid,
  output logic [31:0] mRspRdata,
  output logic        sReqValid,
  input  logic        sReqReady,
  output logic        sReqWrite,
  output logic [31:0] sReqAddr,
  output logic [31:0] sReqWdata,
  output logic        sLock,
  input  logic        sRspValid,
  input  logic [31:0] sRspRdata
);

  ctrl_strobe_t strobe;
  logic isAliasQ;
  logic isWriteQ;

  bb_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .mReqValid (mReqValid),
    .sReqReady (sReqReady),
    .sRspValid (sRspValid),
    .isAliasQ  (isAliasQ),
    .isWriteQ  (isWriteQ),
    .mReqReady (mReqReady),
    .mRspValid (mRspValid),
    .sReqValid (sReqValid),
    .sReqWrite (sReqWrite),
    .sLock     (sLock),
    .strobe    (strobe)
  );

  bb_datapath #(
    .NUM_REGIONS  (NUM_REGIONS),
    .REGION_BITS  (REGION_BITS),
    .REGION_BASE  (REGION_BASE),
    .ALIAS_OFFSET (ALIAS_OFFSET)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mReqAddr  (mReqAddr),
    .mReqWdata (mReqWdata),
    .mReqWrite (mReqWrite),
    .sRspRdata (sRspRdata),
    .sReqValid (sReqValid),
    .sReqReady (sReqReady),
    .mRspValid (mRspValid),
    .isAliasQ  (isAliasQ),
    .isWriteQ  (isWriteQ),
    .sReqAddr  (sReqAddr),
    .sReqWdata (sReqWdata),
    .mRspRdata (mRspRdata)
  );

endmodule

// File: tb/tb_bitband_xlate.sv
`timescale 1ns/1ps
module tb_bitband_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mReqValid = 1'b0;
  logic        mReqReady;
  logic        mReqWrite = 1'b0;
  logic [31:0] mReqAddr = '0;
  logic [31:0] mReqWdata = '0;
  logic        mRspValid;
  logic [31:0] mRspRdata;
  logic        sReqValid;
  logic        sReqReady = 1'b0;
  logic        sReqWrite;
  logic [31:0] sReqAddr;
  logic [31:0] sReqWdata;
  logic        sLock;
  logic        sRspValid = 1'b0;
  logic [31:0] sRspRdata = '0;

  always #4 clk = ~clk;

  bitband_xlate dut (.*);

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Slave memory and independent reference memory
  logic [31:0] mem [logic [31:0]];
  logic [31:0] refMem [logic [31:0]];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hA5C3_0F96;
  endfunction

  // Slave transaction log
  logic [31:0] logAddr[$];
  logic [31:0] logDat[$];
  logic        logWr[$];
  logic        logLk[$];

  int stallCnt = 0;
  always @(negedge clk) begin
    stallCnt++;
    sReqReady <= (stallCnt % 3) != 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      sRspValid <= 1'b0;
    end else begin
      sRspValid <= 1'b0;
      if (sReqValid && sReqReady) begin
        logAddr.push_back(sReqAddr);
        logDat.push_back(sReqWdata);
        logWr.push_back(sReqWrite);
        logLk.push_back(sLock);
        if (sReqWrite) begin
          mem[sReqAddr] = sReqWdata;
          sRspRdata <= '0;
        end else begin
          sRspRdata <= mem.exists(sReqAddr) ? mem[sReqAddr] : pat(sReqAddr);
        end
        sRspValid <= 1'b1;
      end
    end
  end

  // Scoreboard
  logic [31:0] expData[$];
  bit          expChk[$];
  string       expReq[$];

  always @(negedge clk) begin
    if (rstN && mRspValid) begin
      check(sRspValid === 1'b1, "R7 response with slave", {31'b0, sRspValid}, 32'h1);
      if (expData.size() == 0) begin
        check(1'b0, "R7 unexpected response", mRspRdata, 32'h0);
      end else begin
        logic [31:0] e;
        bit c;
        string r;
        e = expData.pop_front();
        c = expChk.pop_front();
        r = expReq.pop_front();
        if (c) check(mRspRdata === e, r, mRspRdata, e);
      end
    end
  end

  function automatic bit isAlias(input logic [31:0] a);
    return (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
  endfunction

  task automatic doOp(input bit wr, input logic [31:0] addr, input logic [31:0] data, input string req);
    logic [31:0] word, cur, expWord;
    int bitN;
    bit al;
    int waitN;
    al = isAlias(addr);
    // Reverse mapping written from the requirement formula
    word = (addr[30] ? 32'h4000_0000 : 32'h2000_0000) + (((addr - (addr & 32'hFE00_0000)) >> 5) & 32'h000F_FFFC);
    bitN = int'(((addr >> 5) & 3) * 8 + ((addr >> 2) & 7));
    logAddr.delete(); logDat.delete(); logWr.delete(); logLk.delete();
    if (al) begin
      cur = refMem.exists(word) ? refMem[word] : pat(word);
      expWord = cur;
      expWord[bitN] = data[0];
      if (wr) begin
        refMem[word] = expWord;
        expData.push_back('0); expChk.push_back(0);
      end else begin
        expData.push_back({31'b0, cur[bitN]}); expChk.push_back(1);
      end
    end else begin
      expWord = data;
      if (wr) begin
        refMem[addr] = data;
        expData.push_back('0); expChk.push_back(0);
      end else begin
        expData.push_back(refMem.exists(addr) ? refMem[addr] : pat(addr)); expChk.push_back(1);
      end
    end
    expReq.push_back(req);
    @(negedge clk);
    mReqValid = 1'b1; mReqWrite = wr; mReqAddr = addr; mReqWdata = data;
    while (!mReqReady) @(negedge clk);
    @(negedge clk);
    mReqValid = 1'b0;
    check(mReqReady === 1'b0, "R6 ready low while busy", {31'b0, mReqReady}, 32'h0);
    waitN = 0;
    while (expData.size() != 0 && waitN < 100) begin @(negedge clk); waitN++; end
    @(negedge clk);
    if (al && wr) begin
      check(logAddr.size() == 2, "R6 rmw has two slave transactions", logAddr.size(), 2);
      if (logAddr.size() == 2) begin
        check(logAddr[0] == word && logWr[0] == 0 && logLk[0], {req, " rmw read"}, logAddr[0], word);
        check(logAddr[1] == word && logWr[1] == 1 && logLk[1], "R6 rmw locked write", logAddr[1], word);
        check(logDat[1] == expWord, "R5 rmw write data", logDat[1], expWord);
      end
    end else if (al) begin
      check(logAddr.size() == 1 && logAddr[0] == word && logWr[0] == 0, {req, " alias read word"},
            logAddr.size() > 0 ? logAddr[0] : 32'hDEAD, word);
    end else begin
      check(logAddr.size() == 1 && logAddr[0] == addr && logWr[0] == wr && !logLk[0], "R1 passthrough request",
            logAddr.size() > 0 ? logAddr[0] : 32'hDEAD, addr);
      if (wr && logAddr.size() == 1) check(logDat[0] == data, "R1 passthrough data", logDat[0], data);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(mReqReady === 1'b1, "R8 reset ready", {31'b0, mReqReady}, 32'h1);
    check(sReqValid === 1'b0, "R8 reset slave valid", {31'b0, sReqValid}, 32'h0);
    check(mRspValid === 1'b0, "R8 reset response", {31'b0, mRspValid}, 32'h0);

    doOp(1, 32'h2000_0300, 32'h1234_5678, "R1 passthrough write");
    doOp(0, 32'h2000_0300, 32'h0, "R1 passthrough read");
    doOp(0, 32'h2200_6008, 32'h0, "R2 R4 alias read bit2 zero");
    doOp(1, 32'h2200_6008, 32'hFFFF_FFFF, "R2 R5 alias set bit2");
    doOp(0, 32'h2000_0300, 32'h0, "R5 word after set 0x1234567C");
    check(refMem[32'h2000_0300] == 32'h1234_567C, "R5 reference word", refMem[32'h2000_0300], 32'h1234_567C);
    doOp(0, 32'h2200_6008, 32'h0, "R4 alias read one");
    doOp(1, 32'h2200_6008, 32'hFFFF_FFFE, "R5 clear uses bit0 only");
    doOp(0, 32'h2000_0300, 32'h0, "R5 word after clear");
    doOp(1, 32'h4200_023C, 32'h0000_0001, "R3 periph alias set bit15");
    doOp(0, 32'h4000_0010, 32'h0, "R3 periph word");
    doOp(0, 32'h4200_023C, 32'h0, "R3 R4 periph alias read");
    doOp(1, 32'h4000_0010, 32'h0000_0000, "R1 periph passthrough write");
    doOp(0, 32'h4200_023C, 32'h0, "R3 periph bit cleared");
    doOp(0, 32'h1000_0040, 32'h0, "R1 other region read");
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      a = (i % 2 ? 32'h4200_0000 : 32'h2200_0000) + 32'((i * 37) % 1024) * 4;
      doOp(i % 3 == 0, a, 32'(i * 7), "R2 R3 R5 mixed alias");
      doOp(0, (i % 2 ? 32'h4000_0000 : 32'h2000_0000) + 32'(((i * 37) % 1024) / 8 * 4) / 4 * 4 / 4 * 4 & 32'hFFFF_FFFC,
           32'h0, "R1 mixed word read");
    end
    finish();
  end

endmodule